// File: doc/BRIEF.md
# Fractional Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a fixed-point signal-processing datapath. It takes two signed 24-bit fractions in 1.23 format and multiplies them. The 2.46 product is moved up one bit so that it lines up as a 1.47 fraction. The aligned product is then added into, or loaded into, one of two 56-bit accumulators. Each accumulator has eight guard bits above the 1.47 field, so that long sums can grow past full scale without wrapping.

An opcode picks one of four operations: clear, accumulate, accumulate-then-round, and multiply-load. The round variant is meant for the last term of a sum. It rounds the total to the 24-bit word width, half-up, at the bit just below the result LSB. After every accepted operation the unit shows three things: the full value of the accumulator it touched, a 24-bit word that saturates when the accumulator is out of range, and an overflow flag. All outputs register one clock after the valid strobe.

Top module: `frac_mac`

## Requirements
- R1: After reset both accumulators are zero, `acc_o`, `res_o` and `ovf_o` are zero, and `res_valid_o` is low.
- R2: Operation 3 (multiply-load) writes the signed product of `a_i` and `b_i` into the selected accumulator. The product is shifted left one bit and sign-extended to 56 bits, so the 1.47 value sits in bits 47:0.
- R3: Operation 1 (accumulate) adds the aligned product to the selected accumulator, modulo 2^56.
- R4: Operation 0 (clear) sets the selected accumulator to zero.
- R5: Operation 2 (accumulate-round) adds the aligned product, then adds 2^23 and zeroes bits 23:0 of the sum.
- R6: `acc_sel_i` picks the destination (0 = first accumulator, 1 = second). An operation never changes the accumulator it does not select.
- R7: `res_o` is accumulator bits 47:24 when bits 55:47 all agree. Otherwise it is 24'h7FFFFF for a non-negative accumulator (bit 55 = 0) and 24'h800000 for a negative one.
- R8: `ovf_o` is high exactly when accumulator bits 55:48 differ from bit 47.
- R9: `acc_o`, `res_o` and `ovf_o` reflect the selected accumulator one clock after `valid_i`, and `res_valid_o` follows `valid_i` with a one-cycle delay. While `valid_i` is low, the accumulators and these three outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | 0 clear, 1 accumulate, 2 accumulate-round, 3 multiply-load |
| acc_sel_i | input | 1 | Destination accumulator |
| a_i | input | 24 | Operand, 1.23 signed |
| b_i | input | 24 | Operand, 1.23 signed |
| acc_o | output | 56 | Updated accumulator value |
| res_o | output | 24 | Saturated 1.23 result |
| ovf_o | output | 1 | Guard bits disagree with the 1.47 sign |
| res_valid_o | output | 1 | Outputs updated this cycle |

## Verification
The bench drives full-scale negative times full-scale negative. A design that takes the shifted product at only 48 bits would turn this case into -1 instead of an overflowing +1. It forces rounding at exactly one half, for both a positive and a negative sum, to catch round-to-nearest-even or rounding toward zero. It builds sums past positive and past negative full scale, where a readout that truncates instead of clamping would wrap the sign. It also loads one accumulator and then works the other, to expose a select that leaks writes.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
  typedef enum logic [1:0] {
    OP_CLR  = 2'd0,
    OP_MAC  = 2'd1,
    OP_MACR = 2'd2,
    OP_MUL  = 2'd3
  } mac_op_e;
endpackage

// File: rtl/frac_mac_mult.sv
module frac_mac_mult #(
  parameter int OP_W  = 24,
  parameter int ACC_W = 56
) (
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [ACC_W-1:0] prod_o
);
  localparam int PROD_W = 2 * OP_W;
  localparam int EXT_W  = ACC_W - PROD_W - 1;

  logic signed [PROD_W-1:0] raw;

  assign raw    = $signed(a_i) * $signed(b_i);
  // 2.46 -> 1.47, keep the extra top bit so -1 * -1 stays positive
  assign prod_o = {{EXT_W{raw[PROD_W-1]}}, raw, 1'b0};
endmodule

// File: rtl/frac_mac_rnd.sv
module frac_mac_rnd #(
  parameter int ACC_W   = 56,
  parameter int RND_POS = 23
) (
  input  logic [ACC_W-1:0] val_i,
  output logic [ACC_W-1:0] val_o
);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << RND_POS;
  localparam logic [ACC_W-1:0] KEEP = ~((ACC_W'(1) << (RND_POS + 1)) - ACC_W'(1));

  logic [ACC_W-1:0] bumped;

  assign bumped = val_i + HALF;
  assign val_o  = bumped & KEEP;
endmodule

// File: rtl/frac_mac_sat.sv
module frac_mac_sat #(
  parameter int OP_W   = 24,
  parameter int ACC_W  = 56,
  parameter int FRAC_W = 47
) (
  input  logic [ACC_W-1:0] val_i,
  output logic [OP_W-1:0]  res_o,
  output logic             ovf_o
);
  localparam int HI_W = ACC_W - FRAC_W;
  localparam logic [OP_W-1:0] POS_MAX = {1'b0, {(OP_W-1){1'b1}}};
  localparam logic [OP_W-1:0] NEG_MIN = {1'b1, {(OP_W-1){1'b0}}};

  logic [HI_W-1:0] hi;

  assign hi    = val_i[ACC_W-1:FRAC_W];
  assign ovf_o = !((&hi) || !(|hi));

  always_comb begin
    if (!ovf_o)               res_o = val_i[FRAC_W -: OP_W];
    else if (val_i[ACC_W-1])  res_o = NEG_MIN;
    else                      res_o = POS_MAX;
  end
endmodule

// File: rtl/frac_mac_acc.sv
module frac_mac_acc
  import frac_mac_pkg::*;
#(
  parameter int OP_W  = 24,
  parameter int ACC_W = 56,
  parameter int N_ACC = 2,
  parameter int SEL_W = (N_ACC > 1) ? $clog2(N_ACC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  mac_op_e          op_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [ACC_W-1:0] prod_i,
  output logic [ACC_W-1:0] nxt_o
);
  localparam int GUARD_W = 8;
  localparam int FRAC_W  = ACC_W - GUARD_W - 1;
  localparam int RND_POS = FRAC_W - OP_W;

  logic [N_ACC-1:0][ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] cur, sum, sum_rnd;

  assign cur = acc_q[sel_i];
  assign sum = cur + prod_i;

  frac_mac_rnd #(.ACC_W(ACC_W), .RND_POS(RND_POS)) u_rnd (
    .val_i(sum),
    .val_o(sum_rnd)
  );

  always_comb begin
    unique case (op_i)
      OP_CLR:  nxt_o = '0;
      OP_MAC:  nxt_o = sum;
      OP_MACR: nxt_o = sum_rnd;
      default: nxt_o = prod_i;
    endcase
  end

  for (genvar i = 0; i < N_ACC; i++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  acc_q[i] <= '0;
      else if (valid_i && sel_i == SEL_W'(i))       acc_q[i] <= nxt_o;
    end

    // R4
    p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && op_i == OP_CLR && sel_i == SEL_W'(i) |=> acc_q[i] == '0);
    // R5
    p_round_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && op_i == OP_MACR && sel_i == SEL_W'(i) |=> acc_q[i][RND_POS:0] == '0);
    // R6
    p_unsel_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && sel_i != SEL_W'(i) |=> $stable(acc_q[i]));
    // R9
    p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(acc_q[i]));
  end
endmodule

// File: rtl/frac_mac.sv
module frac_mac
  import frac_mac_pkg::*;
#(
  parameter int OP_W  = 24,
  parameter int ACC_W = 56
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic             acc_sel_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [OP_W-1:0]  res_o,
  output logic             ovf_o,
  output logic             res_valid_o
);
  localparam int GUARD_W = 8;
  localparam int FRAC_W  = ACC_W - GUARD_W - 1;
  localparam logic [OP_W-1:0] POS_MAX = {1'b0, {(OP_W-1){1'b1}}};
  localparam logic [OP_W-1:0] NEG_MIN = {1'b1, {(OP_W-1){1'b0}}};

  logic [ACC_W-1:0] prod, nxt;
  logic [OP_W-1:0]  sat_res;
  logic             sat_ovf;
  mac_op_e          op;

  assign op = mac_op_e'(op_i);

  frac_mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
    .a_i(a_i), .b_i(b_i), .prod_o(prod)
  );

  frac_mac_acc #(.OP_W(OP_W), .ACC_W(ACC_W), .N_ACC(2), .SEL_W(1)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op),
    .sel_i(acc_sel_i), .prod_i(prod), .nxt_o(nxt)
  );

  frac_mac_sat #(.OP_W(OP_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_sat (
    .val_i(nxt), .res_o(sat_res), .ovf_o(sat_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o       <= '0;
      res_o       <= '0;
      ovf_o       <= 1'b0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= valid_i;
      if (valid_i) begin
        acc_o <= nxt;
        res_o <= sat_res;
        ovf_o <= sat_ovf;
      end
    end
  end

  // R9
  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> res_valid_o);
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !res_valid_o && $stable(acc_o) && $stable(res_o));
  // R7
  p_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_o |-> res_o == acc_o[FRAC_W -: OP_W]);
  p_clamp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> res_o == (acc_o[ACC_W-1] ? NEG_MIN : POS_MAX));
  // R3 / R2: accumulate of a zero product leaves the value unchanged
  p_zero_mac_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op == OP_MAC && (a_i == '0 || b_i == '0) && acc_sel_i == $past(acc_sel_i)
    && $past(valid_i) |=> $stable(acc_o));
endmodule

// File: tb/frac_mac_bench.sv
module frac_mac_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        sel = 1'b0;
  logic [23:0] a = '0, b = '0;
  logic [55:0] acc;
  logic [23:0] res;
  logic        ovf, rv;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [55:0] mdl [2];
  logic [55:0] last_acc = '0;
  logic [23:0] last_res = '0;
  logic        last_ovf = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_mac u_frac_mac (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .acc_sel_i(sel),
    .a_i(a), .b_i(b), .acc_o(acc), .res_o(res), .ovf_o(ovf), .res_valid_o(rv)
  );

  function automatic logic [55:0] prod_f(logic [23:0] x, logic [23:0] y);
    logic signed [55:0] sx, sy;
    sx = {{32{x[23]}}, x};
    sy = {{32{y[23]}}, y};
    return (sx * sy) * 56'sd2;
  endfunction

  function automatic logic ovf_f(logic [55:0] v);
    logic signed [55:0] s;
    s = v;
    return (s > 56'sh7FFF_FFFF_FFFF) || (s < -56'sh8000_0000_0000);
  endfunction

  function automatic logic [23:0] sat_f(logic [55:0] v);
    logic signed [55:0] s;
    s = v;
    if (s > 56'sh7FFF_FFFF_FFFF) return 24'h7FFFFF;
    if (s < -56'sh8000_0000_0000) return 24'h800000;
    return v[47:24];
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_op(logic [1:0] o, logic s, logic [23:0] x, logic [23:0] y);
    logic [55:0] e, sum;
    valid = 1'b1; op = o; sel = s; a = x; b = y;
    sum = mdl[s] + prod_f(x, y);
    case (o)
      2'd0: e = '0;
      2'd1: e = sum;
      2'd2: e = (sum + 56'h80_0000) & ~56'hFF_FFFF;
      default: e = prod_f(x, y);
    endcase
    mdl[s] = e;
    @(negedge clk);
    case (o)
      2'd0: chk("R4 clear acc", acc, e);
      2'd1: chk("R3 mac acc", acc, e);
      2'd2: chk("R5 round acc", acc, e);
      default: chk("R2 mul acc", acc, e);
    endcase
    chk("R7 res", res, sat_f(e));
    chk("R8 ovf", ovf, ovf_f(e));
    chk("R9 valid", rv, 1'b1);
    last_acc = e; last_res = sat_f(e); last_ovf = ovf_f(e);
  endtask

  task automatic idle();
    valid = 1'b0; a = $urandom; b = $urandom; op = 2'($urandom);
    @(negedge clk);
    chk("R9 idle valid", rv, 1'b0);
    chk("R9 idle hold acc", acc, last_acc);
    chk("R9 idle hold res", {res, ovf}, {last_res, last_ovf});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mdl[0] = '0; mdl[1] = '0;
    repeat (2) @(negedge clk);
    chk("R1 reset acc", acc, 56'd0);
    chk("R1 reset res", {res, ovf, rv}, 26'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 half times half
    do_op(2'd3, 1'b0, 24'h400000, 24'h400000);
    chk("R2 quarter", res, 24'h200000);
    // R2 -1 * -1 overflows to +1
    do_op(2'd3, 1'b0, 24'h800000, 24'h800000);
    chk("R8 minus one squared", ovf, 1'b1);
    chk("R7 clamp positive", res, 24'h7FFFFF);
    // R4 clear then positive half round
    do_op(2'd0, 1'b0, 24'h123456, 24'h654321);
    do_op(2'd2, 1'b0, 24'h000001, 24'h400000);
    chk("R5 half rounds up", res, 24'h000001);
    do_op(2'd0, 1'b0, 24'h0, 24'h0);
    do_op(2'd2, 1'b0, 24'hFFFFFF, 24'h400000);
    chk("R5 negative half rounds up", acc, 56'd0);
    // R7 drive negative past full scale
    do_op(2'd0, 1'b1, 24'h0, 24'h0);
    for (int i = 0; i < 4; i++) do_op(2'd1, 1'b1, 24'h800000, 24'h7FFFFF);
    chk("R7 clamp negative", res, 24'h800000);
    // R6 A holds while B works
    do_op(2'd3, 1'b0, 24'h300000, 24'h500000);
    for (int i = 0; i < 5; i++) do_op(2'($urandom), 1'b1, $urandom, $urandom);
    do_op(2'd1, 1'b0, 24'h0, 24'h0);
    chk("R6 unselected kept", acc, prod_f(24'h300000, 24'h500000));
    idle();
    for (int i = 0; i < 400; i++) begin
      int r;
      logic [1:0] o;
      r = int'($urandom_range(0, 15));
      o = (r == 0) ? 2'd0 : (r < 3) ? 2'd2 : (r < 5) ? 2'd3 : 2'd1;
      if (r == 15) idle();
      else do_op(o, 1'($urandom), $urandom, $urandom);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule